// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block produces a single output pulse whose resting level is 0. The pulse can be started or ended in three ways: a direct force-high input, a direct force-low input, and a pair of edge-qualified steering inputs (the JK pair) that act only on a rising edge of a slow logical clock. Whenever one of these acts, a down-counter is either loaded with the 16-bit duration input (if the pulse is now high) or cleared (if it is now low). On every other tick the counter counts down by one, and the pulse drops to 0 when the count runs out.

Time advances only on cycles where `tick_en` is high. All inputs are sampled on those ticks only, including the logical clock, whose previous level is kept so that a rising edge is seen once per transition. On cycles without a tick nothing changes. The block is used as a retriggerable timeout: holding the force-high input keeps reloading the count, so the pulse lasts until that input is released and then for the loaded duration.

The controller is a two-state machine: `ST_IDLE` (output 0) and `ST_PULSE` (output 1). Its transitions are START (IDLE to PULSE on a force-high or a J/toggle action), RELOAD (PULSE to PULSE on a force-high or J action), STOP (PULSE to IDLE on a force-low, K or toggle action), EXPIRE (PULSE to IDLE on a non-acting tick whose count is 1 or 0) and HOLD (no change on any other cycle).

Top module: `msp_oneshot`

## Requirements
- R1: A synchronous reset (`rst` high) clears the output, the remaining count and the stored logical-clock level, so a high `lclk_i` on the first tick after reset counts as a rising edge.
- R2: On a tick with `set_i` high and `clr_i` low, the next cycle shows `q_o`=1 and `remaining_o` equal to the `dur_i` value sampled on that tick.
- R3: On a tick with `clr_i` high and `set_i` low, the next cycle shows `q_o`=0 and `remaining_o`=0.
- R4: On a tick with both `set_i` and `clr_i` high, the output becomes 0 when parameter `RST_WINS`=1 (default) and 1 when `RST_WINS`=0, with the count loaded or cleared to match.
- R5: On a tick with `set_i`=`clr_i`=0 and a rising logical-clock edge (`lclk_i` high now, low on the previous tick), `j_i` alone loads the pulse (Q=1, count=`dur_i`) and `k_i` alone ends it (Q=0, count=0); with neither, the tick is a plain countdown tick.
- R6: With both `j_i` and `k_i` high on such an edge the output inverts; inverting a running pulse ends it early and clears the count.
- R7: The logical clock is sampled only on ticks; a level held high produces one edge only, and a high level seen only between ticks is not an edge.
- R8: On a non-acting tick the count decreases by one, saturating at 0; Q is forced to 0 on the tick where the count was 1 or 0, so a duration N keeps Q high for N non-acting ticks and a duration 0 drops it on the first.
- R9: Holding `set_i` high reloads the count on every tick, so the pulse lasts until `set_i` is released plus the duration then loaded.
- R10: On a cycle with `tick_en` low, `q_o` and `remaining_o` do not change.
- R11: `set_i` or `clr_i` take priority over a simultaneous J/K edge action; `busy_o` is high exactly when `remaining_o` is nonzero, and Q=0 always implies a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time step; all behaviour advances only when high |
| set_i | input | 1 | Force output high and load the count |
| clr_i | input | 1 | Force output low and clear the count |
| j_i | input | 1 | Load request on a logical-clock rising edge |
| k_i | input | 1 | Stop request on a logical-clock rising edge |
| lclk_i | input | 1 | Logical clock, edge-detected at ticks |
| dur_i | input | 16 | Pulse duration in ticks, read when triggered |
| q_o | output | 1 | Pulse output, rests at 0 |
| busy_o | output | 1 | High while the remaining count is nonzero |
| remaining_o | output | 16 | Ticks left in the current pulse |

## Verification
The in-design assertions watch, on every cycle, the per-tick effects of the direct inputs and their dominance, the single-step countdown and its saturation, the freeze on non-tick cycles, the inversion on a toggle edge, and the invariant that an idle output carries no count. What only the bench scenarios show are the sequences: edge detection across held or between-tick logical-clock levels, the exact tick on which a pulse of a given length ends, a held force-high stretching the pulse, and the set-dominant variant, all compared tick by tick against a bench model under random stimulus.

// File: rtl/msp_pkg.sv
package msp_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } msp_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_STOP   = 2'd2,
        ACT_INVERT = 2'd3
    } msp_act_e;
endpackage

// File: rtl/msp_edge.sv
module msp_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else if (tick_en)
            prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/msp_trig.sv
module msp_trig
    import msp_pkg::*;
#(
    parameter bit RST_WINS = 1'b1
) (
    input  logic     tick_en,
    input  logic     set_i,
    input  logic     clr_i,
    input  logic     j_i,
    input  logic     k_i,
    input  logic     rise_i,
    output msp_act_e act_o
);
    msp_act_e direct_act;

    generate
        if (RST_WINS) begin : g_reset_wins
            always_comb direct_act = clr_i ? ACT_STOP : ACT_LOAD;
        end else begin : g_set_wins
            always_comb direct_act = set_i ? ACT_LOAD : ACT_STOP;
        end
    endgenerate

    always_comb begin
        act_o = ACT_NONE;
        if (tick_en) begin
            if (set_i || clr_i)
                act_o = direct_act;
            else if (rise_i) begin
                unique case ({j_i, k_i})
                    2'b10:   act_o = ACT_LOAD;
                    2'b01:   act_o = ACT_STOP;
                    2'b11:   act_o = ACT_INVERT;
                    default: act_o = ACT_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/msp_timer.sv
module msp_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= dur_i;
        else if (clear_i)
            cnt_q <= '0;
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q[CNT_W-1:1] == '0);

    // R8: one step down per plain tick
    a_r8_count_down: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !load_i && !clear_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

    // R8: saturation at zero
    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !load_i && !clear_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/msp_oneshot.sv
module msp_oneshot
    import msp_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit RST_WINS = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic             j_i,
    input  logic             k_i,
    input  logic             lclk_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic             q_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] remaining_o
);
    msp_state_e state_q, state_d;
    msp_act_e   act;
    logic       rise;
    logic       last;
    logic       tmr_load, tmr_clear, tmr_dec;

    msp_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .lvl_i   (lclk_i),
        .rise_o  (rise)
    );

    msp_trig #(.RST_WINS(RST_WINS)) u_trig (
        .tick_en (tick_en),
        .set_i   (set_i),
        .clr_i   (clr_i),
        .j_i     (j_i),
        .k_i     (k_i),
        .rise_i  (rise),
        .act_o   (act)
    );

    // Next state: START, RELOAD, STOP, EXPIRE, HOLD
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (act == ACT_LOAD || act == ACT_INVERT) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                end else if (act == ACT_STOP) begin
                    tmr_clear = 1'b1;
                end
            end
            ST_PULSE: begin
                if (act == ACT_LOAD) begin
                    tmr_load = 1'b1;
                end else if (act == ACT_STOP || act == ACT_INVERT) begin
                    state_d   = ST_IDLE;
                    tmr_clear = 1'b1;
                end else if (tick_en && last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_dec = tick_en && (act == ACT_NONE);

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    msp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load_i  (tmr_load),
        .clear_i (tmr_clear),
        .dec_i   (tmr_dec),
        .dur_i   (dur_i),
        .cnt_o   (remaining_o),
        .last_o  (last)
    );

    // Outputs
    always_comb begin
        q_o    = (state_q == ST_PULSE);
        busy_o = (remaining_o != '0);
    end

    // R2: force-high loads duration
    a_r2_set_loads: assert property (@(posedge clk) disable iff (rst)
        (tick_en && set_i && !clr_i) |=> (q_o && remaining_o == $past(dur_i)));

    // R3: force-low clears
    a_r3_clr_clears: assert property (@(posedge clk) disable iff (rst)
        (tick_en && clr_i && !set_i) |=> (!q_o && remaining_o == '0));

    // R4: dominance when both direct inputs are high
    a_r4_dominance: assert property (@(posedge clk) disable iff (rst)
        (tick_en && clr_i && set_i) |=> (q_o == !RST_WINS));

    // R6: toggle edge inverts output
    a_r6_invert: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !set_i && !clr_i && rise && j_i && k_i) |=> (q_o != $past(q_o)));

    // R10: frozen without a tick
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(q_o) && $stable(remaining_o)));

    // R11: idle output carries no count
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !q_o |-> remaining_o == '0);
endmodule

// File: tb/msp_oneshot_bench.sv
`timescale 1ns/1ps
module msp_oneshot_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0, set_i = 1'b0, clr_i = 1'b0;
    logic        j_i = 1'b0, k_i = 1'b0, lclk_i = 1'b0;
    logic [15:0] dur_i = '0;
    logic        q_a, busy_a, q_b, busy_b;
    logic [15:0] rem_a, rem_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state {prev_lclk, q, count}
    logic [17:0] ma, mb;

    always #4 clk = ~clk;

    msp_oneshot u_msp_oneshot (
        .clk(clk), .rst(rst), .tick_en(tick_en), .set_i(set_i), .clr_i(clr_i),
        .j_i(j_i), .k_i(k_i), .lclk_i(lclk_i), .dur_i(dur_i),
        .q_o(q_a), .busy_o(busy_a), .remaining_o(rem_a)
    );

    msp_oneshot #(.RST_WINS(1'b0)) u_msp_oneshot_sd (
        .clk(clk), .rst(rst), .tick_en(tick_en), .set_i(set_i), .clr_i(clr_i),
        .j_i(j_i), .k_i(k_i), .lclk_i(lclk_i), .dur_i(dur_i),
        .q_o(q_b), .busy_o(busy_b), .remaining_o(rem_b)
    );

    function automatic logic [17:0] model_next(input bit rst_wins, input logic [17:0] st,
        input logic t, input logic s, input logic c, input logic j, input logic k,
        input logic l, input logic [15:0] d);
        logic prev, q, rise;
        logic [15:0] cnt;
        prev = st[17]; q = st[16]; cnt = st[15:0];
        if (!t) return st;
        rise = l & ~prev;
        prev = l;
        if (s || c) begin
            q = rst_wins ? !c : s;
            cnt = q ? d : 16'd0;
        end else if (rise && (j || k)) begin
            q = (j && k) ? !q : j;
            cnt = q ? d : 16'd0;
        end else begin
            if (cnt <= 16'd1) q = 1'b0;
            if (cnt != 16'd0) cnt = cnt - 16'd1;
        end
        return {prev, q, cnt};
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (q_a !== ma[16] || rem_a !== ma[15:0] || busy_a !== (ma[15:0] != 0)) begin
            errors++;
            $display("FAIL %s reset-wins: q=%0b rem=%0d busy=%0b expected q=%0b rem=%0d",
                     tag, q_a, rem_a, busy_a, ma[16], ma[15:0]);
        end
        checks++;
        if (q_b !== mb[16] || rem_b !== mb[15:0] || busy_b !== (mb[15:0] != 0)) begin
            errors++;
            $display("FAIL %s set-wins: q=%0b rem=%0d busy=%0b expected q=%0b rem=%0d",
                     tag, q_b, rem_b, busy_b, mb[16], mb[15:0]);
        end
    endtask

    // Called at a negedge: drive, advance one clock, compare at next negedge
    task automatic step(input string tag, input logic t, input logic s, input logic c,
                        input logic j, input logic k, input logic l, input logic [15:0] d);
        tick_en = t; set_i = s; clr_i = c; j_i = j; k_i = k; lclk_i = l; dur_i = d;
        ma = model_next(1'b1, ma, t, s, c, j, k, l, d);
        mb = model_next(1'b0, mb, t, s, c, j, k, l, d);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick_en = 0; set_i = 0; clr_i = 0; j_i = 0; k_i = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ma = '0; mb = '0;
        compare("R1 reset state");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        lclk_i = 1'b1;
        do_reset();
        // R1: held-high logical clock is an edge on first tick
        step("R1 first tick edge", 1, 0, 0, 1, 0, 1, 16'd5);
        step("R7 held level no new edge", 1, 0, 0, 0, 1, 1, 16'd5);
        // R3 clear
        step("R3 clear", 1, 0, 1, 0, 0, 1, 16'd9);
        // R2 + R8 pulse of 3
        step("R2 set", 1, 1, 0, 0, 0, 0, 16'd3);
        step("R8 count 2", 1, 0, 0, 0, 0, 0, 16'd0);
        step("R10 no tick", 0, 1, 1, 1, 1, 1, 16'd7);
        step("R10 no tick", 0, 0, 1, 0, 0, 0, 16'd7);
        step("R8 count 1", 1, 0, 0, 0, 0, 0, 16'd0);
        step("R8 expire", 1, 0, 0, 0, 0, 0, 16'd0);
        step("R8 saturate", 1, 0, 0, 0, 0, 0, 16'd0);
        // R8 duration zero
        step("R8 dur zero load", 1, 1, 0, 0, 0, 0, 16'd0);
        step("R8 dur zero drop", 1, 0, 0, 0, 0, 0, 16'd0);
        // R9 held set
        for (int i = 0; i < 5; i++) step("R9 held set", 1, 1, 0, 0, 0, 0, 16'd2);
        step("R9 release", 1, 0, 0, 0, 0, 0, 16'd2);
        step("R9 release", 1, 0, 0, 0, 0, 0, 16'd2);
        // R4 both
        step("R4 both direct", 1, 1, 1, 0, 0, 0, 16'd4);
        step("R4 both direct", 1, 1, 1, 0, 0, 0, 16'd6);
        step("R3 clear both", 1, 0, 1, 0, 0, 0, 16'd0);
        // R5 J and K
        step("R5 J edge", 1, 0, 0, 1, 0, 1, 16'd8);
        step("R5 low", 1, 0, 0, 0, 0, 0, 16'd8);
        step("R5 K edge", 1, 0, 0, 0, 1, 1, 16'd8);
        step("R5 low", 1, 0, 0, 0, 0, 0, 16'd8);
        step("R5 no J K edge", 1, 0, 0, 0, 0, 1, 16'd8);
        step("R5 low", 1, 0, 0, 0, 0, 0, 16'd8);
        // R6 toggle on, toggle off early
        step("R6 invert up", 1, 0, 0, 1, 1, 1, 16'd10);
        step("R6 low", 1, 0, 0, 0, 0, 0, 16'd10);
        step("R6 invert down", 1, 0, 0, 1, 1, 1, 16'd10);
        // R7 high only between ticks
        step("R7 low", 1, 0, 0, 0, 0, 0, 16'd3);
        step("R7 high no tick", 0, 0, 0, 1, 0, 1, 16'd3);
        step("R7 low on tick", 1, 0, 0, 1, 0, 0, 16'd3);
        // R11 direct wins over edge
        step("R11 clr beats J", 1, 0, 1, 1, 0, 1, 16'd3);
        step("R11 low", 1, 0, 0, 0, 0, 0, 16'd3);
        step("R11 set beats K", 1, 1, 0, 0, 1, 1, 16'd3);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic t, s, c;
            t = ($urandom % 4) != 0;
            s = ($urandom % 10) == 0;
            c = ($urandom % 12) == 0;
            step("random mix", t, s, c, 1'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom % 9));
        end
        lclk_i = 1'b1;
        do_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule